// File: doc/BRIEF.md
# SCSI Controller Register Stub

This block is the byte-wide register front end of a SCSI bus controller that never drives a real SCSI bus. A host reaches it over a plain memory-mapped port with a write strobe, a read strobe, a shared byte address and 8-bit data. Registers sit on a 4-byte stride. Address bits [5:2] pick one of sixteen byte registers. All other address bits are ignored.

Software writes command codes to the command register (index 3). A select-with-attention command does not start a bus phase. It loads at once a fixed result: the target is absent, so the status, interrupt-reason and sequence registers hold a disconnect pattern and the interrupt line goes high. A chip-reset command puts everything back to the power-up state. Registers that real hardware treats as read-only ignore host writes. The command register is not stored, so it always reads as zero.

There is no data stream through this block. Every pin is a plain control or status pin, with no valid/ready handshake and no back-pressure. `rd_data` shows the addressed register while `rd_en` is high and is zero otherwise.

Top module: `scsi_regstub`

## Requirements
- R1: While `rst_n` is low, and after reset is released, every register reads 0x00 except index 14, which reads 0x04, and `irq` is low.
- R2: The register index is `addr[5:2]`. Address bits [1:0] and bits 6 and up have no effect on which register is reached.
- R3: A write to index 0, 1, 2 or 8 stores `wr_data`, and a later read of that index returns it unchanged.
- R4: Writes to indices 4 to 7 and 9 to 15 leave the stored value unchanged. Index 3 is never stored and always reads 0x00.
- R5: A write to index 3 selects a command from `wr_data[6:0]` only. Bit 7 does not change the decoded command.
- R6: Command 0x42 sets index 4 to 0x1A, index 5 to 0x20 and index 6 to 0x04, and sets `irq` high from the next clock edge.
- R7: Commands 0x00, 0x03 and 0x1A, and every code not listed in R6 or R8, leave all registers and `irq` unchanged.
- R8: Command 0x02 returns every register to its R1 value and drives `irq` low from the next clock edge.
- R9: `irq` stays high until a read of index 5, and is low from the clock edge that ends that read. Reads of other indices do not clear it. No read changes a stored value.
- R10: When `rst_n` is low in the same cycle as a write or a command, the reset wins: the write is lost and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe for the current cycle |
| rd_en | input | 1 | Byte read strobe for the current cycle |
| addr | input | 8 | Byte address shared by read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Addressed register while `rd_en` is high, otherwise 0x00 |
| irq | output | 1 | Level interrupt raised by a select command |

## Verification
The assertions assume that `rst_n` is low for at least one rising edge at start-up. They also assume that every input holds a known 0 or 1 at each edge, and that read and write share one address in any cycle, so a read of index 5 can never coincide with a command write. The stimulus drives every input from tasks on the falling edge, keeps all strobes at zero during the start-up reset, and never leaves an input undriven. It also asserts reset on purpose in the middle of a command write, to show that reset takes priority there.

// File: rtl/scsi_stub_pkg.sv
package scsi_stub_pkg;

  localparam int DATA_W  = 8;
  localparam int IDX_W   = 4;
  localparam int NREG    = 1 << IDX_W;

  localparam int CMD_IDX  = 3;
  localparam int STAT_IDX = 4;
  localparam int ISR_IDX  = 5;
  localparam int SEQ_IDX  = 6;
  localparam int ID_IDX   = 14;

  localparam logic [DATA_W-1:0] ID_VALUE       = 8'h04;
  localparam logic [DATA_W-1:0] SEL_STAT_VALUE = 8'h1A;
  localparam logic [DATA_W-1:0] SEL_ISR_VALUE  = 8'h20;
  localparam logic [DATA_W-1:0] SEL_SEQ_VALUE  = 8'h04;

  typedef enum logic [6:0] {
    CMD_NOP      = 7'h00,
    CMD_CHIP_RST = 7'h02,
    CMD_BUS_RST  = 7'h03,
    CMD_SET_ATN  = 7'h1A,
    CMD_SEL_ATN  = 7'h42
  } cmd_e;

  typedef struct packed {
    logic select;
    logic chip_rst;
  } cmd_act_t;

  function automatic logic [DATA_W-1:0] reset_value(input int idx);
    return (idx == ID_IDX) ? ID_VALUE : '0;
  endfunction

  function automatic logic [DATA_W-1:0] select_value(input int idx);
    case (idx)
      STAT_IDX: return SEL_STAT_VALUE;
      ISR_IDX:  return SEL_ISR_VALUE;
      SEQ_IDX:  return SEL_SEQ_VALUE;
      default:  return '0;
    endcase
  endfunction

  function automatic logic select_loads(input int idx);
    return (idx == STAT_IDX) || (idx == ISR_IDX) || (idx == SEQ_IDX);
  endfunction

endpackage

// File: rtl/ssr_addr_decode.sv
module ssr_addr_decode
  import scsi_stub_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [NREG-1:0] WR_MASK = 16'h0107
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_store,
  output logic              wr_cmd,
  output logic              rd_isr
);

  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  always_comb begin
    idx      = addr[IDX_MSB:IDX_LSB];
    wr_store = wr_en && WR_MASK[idx];
    wr_cmd   = wr_en && (idx == IDX_W'(CMD_IDX));
    rd_isr   = rd_en && (idx == IDX_W'(ISR_IDX));
  end

endmodule

// File: rtl/ssr_cmd_decode.sv
module ssr_cmd_decode
  import scsi_stub_pkg::*;
(
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_act_t          act
);

  cmd_e code;

  always_comb begin
    code = cmd_e'(wr_data[6:0]);
    act  = '0;
    if (wr_cmd) begin
      case (code)
        CMD_SEL_ATN:  act.select   = 1'b1;
        CMD_CHIP_RST: act.chip_rst = 1'b1;
        default:      act          = '0;
      endcase
    end
  end

endmodule

// File: rtl/ssr_reg_bank.sv
module ssr_reg_bank
  import scsi_stub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_store,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  input  cmd_act_t          act,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = reset_value(g);
    localparam logic [DATA_W-1:0] SEL_V = select_value(g);
    localparam logic              SEL_L = select_loads(g);
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_V;
      end else if (act.chip_rst) begin
        q <= RST_V;
      end else if (act.select && SEL_L) begin
        q <= SEL_V;
      end else if (wr_store && (idx == IDX_W'(g))) begin
        q <= wr_data;
      end
    end

    assign regs[g] = q;
  end

  always_comb begin
    rd_data = rd_en ? regs[idx] : '0;
  end

endmodule

// File: rtl/ssr_irq_ctrl.sv
module ssr_irq_ctrl
  import scsi_stub_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cmd_act_t act,
  input  logic     rd_isr,
  output logic     irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (act.chip_rst) begin
      irq <= 1'b0;
    end else if (act.select) begin
      irq <= 1'b1;
    end else if (rd_isr) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/scsi_regstub.sv
module scsi_regstub
  import scsi_stub_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq
);

  localparam logic [NREG-1:0] WR_MASK = 16'h0107;

  logic [IDX_W-1:0] idx;
  logic             wr_store;
  logic             wr_cmd;
  logic             rd_isr;
  cmd_act_t         act;

  ssr_addr_decode #(
    .ADDR_W  (ADDR_W),
    .WR_MASK (WR_MASK)
  ) i_dec (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .idx      (idx),
    .wr_store (wr_store),
    .wr_cmd   (wr_cmd),
    .rd_isr   (rd_isr)
  );

  ssr_cmd_decode i_cmd (
    .wr_cmd  (wr_cmd),
    .wr_data (wr_data),
    .act     (act)
  );

  ssr_reg_bank i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (idx),
    .wr_store (wr_store),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .act      (act),
    .rd_data  (rd_data)
  );

  ssr_irq_ctrl i_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .rd_isr (rd_isr),
    .irq    (irq)
  );

endmodule

// File: rtl/scsi_regstub_chk.sv
module scsi_regstub_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              irq
);

  logic is_sel;
  logic is_crst;
  logic rd5;

  always_comb begin
    is_sel  = wr_en && (addr[5:2] == 4'd3) && (wr_data[6:0] == 7'h42);
    is_crst = wr_en && (addr[5:2] == 4'd3) && (wr_data[6:0] == 7'h02);
    rd5     = rd_en && (addr[5:2] == 4'd5);
  end

  // R6: the interrupt only rises after a select command
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(is_sel));

  // R6: a select command raises the interrupt
  p_sel_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_sel |=> irq);

  // R8: chip reset drops the interrupt
  p_crst_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_crst |=> !irq);

  // R9: a read of index 5 clears a pending interrupt
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && rd5) |=> !irq);

  // R9: the interrupt holds otherwise
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd5 && !is_crst) |=> irq);

  // R4: the command register always reads zero
  p_cmd_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[5:2] == 4'd3) |-> (rd_data == 8'h00));

  // R1: identification register is constant
  p_id_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[5:2] == 4'd14) |-> (rd_data == 8'h04));

  // R9: no read changes a stored value
  p_read_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !is_sel && !is_crst) |=>
      ((rd_en && !wr_en && $stable(addr)) -> $stable(rd_data)));

endmodule

bind scsi_regstub scsi_regstub_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_scsi_regstub.sv
module test_scsi_regstub;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_regs [16];
  logic       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regstub i_scsi_regstub (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
  );

  function automatic void model_reset();
    for (int i = 0; i < 16; i++) m_regs[i] = (i == 14) ? 8'h04 : 8'h00;
    m_irq = 1'b0;
  endfunction

  function automatic void model_clock(input logic w, input logic r,
                                      input logic [7:0] a, input logic [7:0] d);
    int ix;
    ix = int'(a[5:2]);
    if (r && ix == 5) m_irq = 1'b0;
    if (w) begin
      if (ix == 3) begin
        if (d[6:0] == 7'h42) begin
          m_regs[4] = 8'h1A; m_regs[5] = 8'h20; m_regs[6] = 8'h04; m_irq = 1'b1;
        end else if (d[6:0] == 7'h02) begin
          model_reset();
        end
      end else if (ix == 0 || ix == 1 || ix == 2 || ix == 8) begin
        m_regs[ix] = d;
      end
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model at the rising edge
  task automatic step(input logic rst, input logic w, input logic r,
                      input logic [7:0] a, input logic [7:0] d, input string tag);
    logic [7:0] exp_rd;
    rst_n = ~rst; wr_en = w; rd_en = r; addr = a; wr_data = d;
    if (rst) model_reset();
    #2;
    exp_rd = r ? m_regs[a[5:2]] : 8'h00;
    check(tag, "rd_data", rd_data, exp_rd);
    check(tag, "irq", {7'b0, irq}, {7'b0, m_irq});
    @(posedge clk);
    if (!rst) model_clock(w, r, a, d);
    @(negedge clk);
  endtask

  task automatic rd(input int ix, input string tag);
    step(1'b0, 1'b0, 1'b1, 8'(ix << 2), 8'h00, tag);
  endtask

  task automatic wr(input int ix, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, 1'b0, 8'(ix << 2), d, tag);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 16; i++) rd(i, tag);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R1");
    step(1'b1, 1'b0, 1'b1, 8'h38, 8'h00, "R1");
    read_all("R1");

    // R2 R3: writable registers, with junk in the ignored address bits
    step(1'b0, 1'b1, 1'b0, 8'hC3, 8'hA5, "R2");
    step(1'b0, 1'b1, 1'b0, 8'h45, 8'h5A, "R2");
    step(1'b0, 1'b1, 1'b0, 8'h8A, 8'h3C, "R2");
    step(1'b0, 1'b1, 1'b0, 8'hE1, 8'hC3, "R2");
    read_all("R3");
    wr(0, 8'hFF, "R3");
    step(1'b0, 1'b1, 1'b1, 8'h00, 8'h11, "R3");
    rd(0, "R3");

    // R4: protected registers and the unstored command register
    for (int i = 4; i < 16; i++) if (i != 8) wr(i, 8'hEE, "R4");
    read_all("R4");

    // R7 R5: accepted and unknown commands without effect
    wr(3, 8'h00, "R7");
    wr(3, 8'h03, "R7");
    wr(3, 8'h1A, "R7");
    wr(3, 8'h7F, "R7");
    wr(3, 8'h55, "R7");
    wr(3, 8'hC0, "R5");
    read_all("R7");

    // R5 R6: select with bit 7 set
    wr(3, 8'hC2, "R5");
    rd(4, "R6"); rd(6, "R6"); rd(14, "R6"); rd(4, "R9");
    rd(5, "R9");
    rd(5, "R9");
    read_all("R9");

    // R8: chip reset while the interrupt is pending, with bit 7 set
    wr(3, 8'h42, "R6");
    wr(3, 8'h82, "R8");
    read_all("R8");

    // R10: reset on top of a write and a select
    wr(1, 8'h77, "R10");
    step(1'b1, 1'b1, 1'b0, 8'h0C, 8'h42, "R10");
    step(1'b1, 1'b1, 1'b0, 8'h00, 8'h99, "R10");
    read_all("R10");
    wr(3, 8'h42, "R6");
    wr(3, 8'h1A, "R7");
    rd(5, "R9");
    rd(5, "R9");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule